// File: doc/BRIEF.md
# UART transmitter with stick parity

This block turns bytes from a small transmit store into asynchronous serial frames on a single output line. A bus-side write strobe pushes a byte into the store. The store is either a first-in first-out queue of `FIFO_DEPTH` entries or a one-byte holding register, chosen at run time. A frame sequencer, paced by an oversampling tick, pulls bytes from the store and sends each one as a start bit, 5 to 8 data bits LSB first, an optional parity bit and one or two stop bits. Each bit lasts `TICKS_PER_BIT` ticks, 16 by default.

The parity bit can be odd, even, or stuck at a fixed level. A break request holds the line low, but only once the character on the wire is complete. A clear-to-send input can gate the start of each new character. The character format is captured when a character starts. When one frame ends and another byte is waiting, the next start bit follows the last stop bit directly, with no idle time in between. The busy output tells software when the line and the store are both drained.

Top module: `utx_serializer`

## Requirements
- R1: While no frame is being sent and break is not requested, `txd` is 1. A frame is a 0 start bit, then the data bits LSB first, then the stop bits at 1. Each bit lasts `TICKS_PER_BIT` ticks of `baud_tick`. `word_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Upper byte bits beyond that count are not sent.
- R2: When `parity_en`=1, one parity bit follows the data bits. With `even_sel`=1 the count of ones over the data and parity bits is even; with `even_sel`=0 it is odd. With `parity_en`=0 no parity bit is sent.
- R3: When `stick_en`=1 and `parity_en`=1, the parity bit is 1 if `even_sel`=0 and 0 if `even_sel`=1. When `parity_en`=0, `stick_en` has no effect on the frame.
- R4: When `two_stop`=1, two stop bits are sent. `busy` stays 1 until the last stop bit has ended.
- R5: A character starts at the first clock edge where `baud_tick`=1, the store holds data and starting is allowed. Writing a byte to an empty store with `baud_tick` held high makes `txd` fall one cycle after the write edge. A waiting byte starts on the edge that ends the previous frame's last stop bit, with no idle gap.
- R6: `busy` is 1 from the cycle after a byte is accepted, even with `tx_enable`=0. It stays 1 while the store is non-empty or a frame is in progress, and falls in the cycle after the last stop bit ends. `tx_empty` tracks the store only.
- R7: After reset, `txd`=1, `busy`=0, `tx_empty`=1 and `tx_full`=0.
- R8: Clearing `tx_enable` during a frame lets that frame finish unchanged. No further character starts until `tx_enable` is 1 again.
- R9: With `cts_flow_en`=1, a character starts only while `cts_ok`=1. `cts_ok` is looked at only when a character would start, so dropping it during a frame does not shorten the frame.
- R10: While `send_break`=1, `txd` is held at 0 once the current frame has finished, and no new character starts. Clearing it lets waiting data go out.
- R11: With `fifo_mode`=1 the store holds `FIFO_DEPTH` bytes and sends them in write order. With `fifo_mode`=0 it holds one byte. `tx_full` is 1 at capacity, and a write while full is dropped.
- R12: With `baud_tick`=0 the transmitter does not advance, and a pending character does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, `TICKS_PER_BIT` per bit |
| wr_en | input | 1 | Write strobe into the transmit store |
| wr_data | input | 8 | Byte to transmit |
| fifo_mode | input | 1 | 1: queue of `FIFO_DEPTH` bytes, 0: single holding byte |
| tx_enable | input | 1 | Allows new characters to start |
| word_len | input | 2 | Data bit count code (00=5 .. 11=8) |
| parity_en | input | 1 | Adds a parity bit |
| even_sel | input | 1 | 1 even, 0 odd; level select in stick mode |
| stick_en | input | 1 | Forces the parity bit to a fixed level |
| two_stop | input | 1 | Sends two stop bits |
| send_break | input | 1 | Holds the line low after the current frame |
| cts_flow_en | input | 1 | Gates character starts with `cts_ok` |
| cts_ok | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Store non-empty or frame in progress |
| tx_full | output | 1 | Store at capacity |
| tx_empty | output | 1 | Store holds no byte |

## Verification
With the tick held high, a write is accepted on one edge. `busy` and `tx_empty` change right after that edge, and the start bit appears one edge later, so the bench checks that the falling edge of `txd` is seen exactly one sample after the write. Each following bit is sampled in its middle, at 8 + 16·k cycles after the start, taken on the falling clock edge. `busy` is checked one cycle before the frame's end edge and again one cycle after it. For chained frames, the next start bit must be seen on the very next sample after a stop bit.

// File: rtl/utx_pkg.sv
package utx_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } tx_phase_e;

   // number of data bits for a word-length code: 5 + code
   function automatic logic [3:0] char_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

   // parity bit for the low nb bits of d
   function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                      input logic [3:0]        nb,
                                      input logic              even,
                                      input logic              stick);
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < int'(nb)) acc = acc ^ d[i];
      end
      if (stick) return ~even;
      return even ? acc : ~acc;
   endfunction

endpackage

// File: rtl/utx_store.sv
module utx_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("utx_store: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  cap;
   logic              push;

   assign cap     = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
   assign full    = (count >= cap);
   assign empty   = (count == '0);
   assign push    = wr_en && !full;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R11: the sequencer never takes a byte from an empty store
   assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

   // R11: a write into a full store leaves the fill level unchanged
   assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !pop) |=> $stable(count));

endmodule

// File: rtl/utx_frame_seq.sv
module utx_frame_seq
   import utx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              avail,
   input  logic [CHAR_W-1:0] char_in,
   input  logic              tx_enable,
   input  logic              cts_flow_en,
   input  logic              cts_ok,
   input  logic              send_break,
   input  logic [1:0]        word_len,
   input  logic              parity_en,
   input  logic              even_sel,
   input  logic              stick_en,
   input  logic              two_stop,
   output logic              pop,
   output logic              txd,
   output logic              active
);

   localparam int SUB_W = $clog2(TICKS_PER_BIT);

   generate
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("utx_frame_seq: TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   tx_phase_e         phase;
   logic [SUB_W-1:0]  sub;
   logic [3:0]        left;
   logic [3:0]        nb_q;
   logic [CHAR_W-1:0] sh;
   logic              par_q, pen_q, two_q;
   logic              bit_end, gate_ok, start_now;

   assign bit_end = baud_tick && (sub == SUB_W'(TICKS_PER_BIT - 1));
   assign gate_ok = tx_enable && (!cts_flow_en || cts_ok) && !send_break;

   always_comb begin
      start_now = baud_tick && avail && gate_ok &&
                  ((phase == PH_IDLE) ||
                   (phase == PH_STOP && bit_end && left == 4'd0));
   end

   assign pop    = start_now;
   assign active = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         sub   <= '0;
         left  <= '0;
         nb_q  <= '0;
         sh    <= '0;
         par_q <= 1'b0;
         pen_q <= 1'b0;
         two_q <= 1'b0;
      end else if (start_now) begin
         phase <= PH_START;
         sub   <= '0;
         sh    <= char_in;
         nb_q  <= char_bits(word_len);
         par_q <= parity_of(char_in, char_bits(word_len), even_sel, stick_en);
         pen_q <= parity_en;
         two_q <= two_stop;
      end else if (phase != PH_IDLE && baud_tick) begin
         if (!bit_end) begin
            sub <= sub + 1'b1;
         end else begin
            sub <= '0;
            unique case (phase)
               PH_START: begin
                  phase <= PH_DATA;
                  left  <= nb_q - 4'd1;
               end
               PH_DATA: begin
                  sh <= sh >> 1;
                  if (left == 4'd0) begin
                     if (pen_q) begin
                        phase <= PH_PARITY;
                     end else begin
                        phase <= PH_STOP;
                        left  <= {3'b000, two_q};
                     end
                  end else begin
                     left <= left - 4'd1;
                  end
               end
               PH_PARITY: begin
                  phase <= PH_STOP;
                  left  <= {3'b000, two_q};
               end
               PH_STOP: begin
                  if (left == 4'd0) phase <= PH_IDLE;
                  else              left  <= left - 4'd1;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (phase)
         PH_IDLE:   txd = !send_break;
         PH_START:  txd = 1'b0;
         PH_DATA:   txd = sh[0];
         PH_PARITY: txd = par_q;
         PH_STOP:   txd = 1'b1;
         default:   txd = 1'b1;
      endcase
   end

   // R9 / R8: a new frame only begins after a tick on which starting was allowed
   assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_START && $past(phase) != PH_START) |->
         $past(baud_tick && tx_enable && (!cts_flow_en || cts_ok) && !send_break));

   // R10: while break is requested an idle line stays idle
   assert_break_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && send_break) |=> (phase == PH_IDLE));

   // R12: without a tick a running frame does not advance
   assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !baud_tick) |=> ($stable(phase) && $stable(sub)));

endmodule

// File: rtl/utx_serializer.sv
module utx_serializer
   import utx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter int FIFO_DEPTH    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       fifo_mode,
   input  logic       tx_enable,
   input  logic [1:0] word_len,
   input  logic       parity_en,
   input  logic       even_sel,
   input  logic       stick_en,
   input  logic       two_stop,
   input  logic       send_break,
   input  logic       cts_flow_en,
   input  logic       cts_ok,
   output logic       txd,
   output logic       busy,
   output logic       tx_full,
   output logic       tx_empty
);

   logic [CHAR_W-1:0] head;
   logic              pop, active;

   utx_store #(
      .DEPTH  (FIFO_DEPTH),
      .DATA_W (CHAR_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_mode (fifo_mode),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .pop       (pop),
      .rd_data   (head),
      .empty     (tx_empty),
      .full      (tx_full)
   );

   utx_frame_seq #(
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_tick   (baud_tick),
      .avail       (!tx_empty),
      .char_in     (head),
      .tx_enable   (tx_enable),
      .cts_flow_en (cts_flow_en),
      .cts_ok      (cts_ok),
      .send_break  (send_break),
      .word_len    (word_len),
      .parity_en   (parity_en),
      .even_sel    (even_sel),
      .stick_en    (stick_en),
      .two_stop    (two_stop),
      .pop         (pop),
      .txd         (txd),
      .active      (active)
   );

   assign busy = !tx_empty || active;

   // R6: a stored byte always shows as busy
   assert_busy_covers_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_empty |-> busy);

   // R1: with nothing to send and no break the line rests high
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !send_break) |-> txd);

endmodule

// File: tb/test_utx_serializer.sv
`timescale 1ns/1ps
module test_utx_serializer;

   typedef struct packed {
      logic [7:0] d;
      logic [1:0] wl;
      logic       pen;
      logic       eps;
      logic       sps;
      logic       two;
      logic       par;
   } vec_t;

   // expected parity bits worked out by hand from R2/R3
   localparam vec_t VEC [9] = '{
      '{8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{8'hA5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      '{8'hA5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h13, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
      '{8'h3F, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
      '{8'h00, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      '{8'hFF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'h7E, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      '{8'hE0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       fifo_mode = 1'b1;
   logic       tx_enable = 1'b1;
   logic [1:0] word_len = 2'd3;
   logic       parity_en = 1'b0;
   logic       even_sel = 1'b0;
   logic       stick_en = 1'b0;
   logic       two_stop = 1'b0;
   logic       send_break = 1'b0;
   logic       cts_flow_en = 1'b0;
   logic       cts_ok = 1'b1;
   logic       txd, busy, tx_full, tx_empty;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #2.5 clk = ~clk;

   utx_serializer i_utx_serializer (
      .clk         (clk),
      .rst_n       (rst_n),
      .baud_tick   (baud_tick),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .fifo_mode   (fifo_mode),
      .tx_enable   (tx_enable),
      .word_len    (word_len),
      .parity_en   (parity_en),
      .even_sel    (even_sel),
      .stick_en    (stick_en),
      .two_stop    (two_stop),
      .send_break  (send_break),
      .cts_flow_en (cts_flow_en),
      .cts_ok      (cts_ok),
      .txd         (txd),
      .busy        (busy),
      .tx_full     (tx_full),
      .tx_empty    (tx_empty)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   // drives one write cycle; returns at the sample just after the write edge
   task automatic put(input logic [7:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_fall(output int waited);
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (txd !== 1'b0 && waited < 3000);
      if (waited >= 3000) chk(0, "R5", "no start bit", waited, 0);
   endtask

   // called at the first sample where txd is low; returns one cycle before frame end
   task automatic decode(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                         input logic par, input logic two, input string req);
      int         nb;
      logic [7:0] got;
      logic [7:0] mask;
      nb   = 5 + int'(wl);
      got  = 8'h00;
      mask = 8'hFF >> (8 - nb);
      repeat (8) @(negedge clk);
      chk(txd == 1'b0, req, "start bit", int'(txd), 0);
      for (int i = 0; i < nb; i++) begin
         repeat (16) @(negedge clk);
         got[i] = txd;
      end
      chk(got == (d & mask), req, "data bits", int'(got), int'(d & mask));
      if (pen) begin
         repeat (16) @(negedge clk);
         chk(txd == par, req, "parity bit", int'(txd), int'(par));
      end
      for (int s = 0; s < 1 + int'(two); s++) begin
         repeat (16) @(negedge clk);
         chk(txd == 1'b1, req, "stop bit", int'(txd), 1);
      end
      repeat (7) @(negedge clk);
      chk(busy == 1'b1, "R4", "busy held to last stop", int'(busy), 1);
   endtask

   task automatic expect_idle(input string req);
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, req, "busy after frame", int'(busy), 0);
      chk(txd == 1'b1, req, "line idle", int'(txd), 1);
      chk(tx_empty == 1'b1, req, "store empty", int'(tx_empty), 1);
   endtask

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      chk(txd == 1'b1, "R7", "txd", int'(txd), 1);
      chk(busy == 1'b0, "R7", "busy", int'(busy), 0);
      chk(tx_empty == 1'b1, "R7", "empty", int'(tx_empty), 1);
      chk(tx_full == 1'b0, "R7", "full", int'(tx_full), 0);

      // vector table: R1 R2 R3 R4 R5 R6
      foreach (VEC[k]) begin
         word_len  = VEC[k].wl;
         parity_en = VEC[k].pen;
         even_sel  = VEC[k].eps;
         stick_en  = VEC[k].sps;
         two_stop  = VEC[k].two;
         put(VEC[k].d);
         chk(busy == 1'b1, "R6", "busy after write", int'(busy), 1);
         wait_fall(w);
         chk(w == 1, "R5", "start latency", w, 1);
         decode(VEC[k].d, VEC[k].wl, VEC[k].pen, VEC[k].par, VEC[k].two, "R1/R2/R3");
         expect_idle("R6");
      end
      word_len = 2'd3; parity_en = 1'b0; even_sel = 1'b0; stick_en = 1'b0; two_stop = 1'b0;

      // R12 tick gating
      baud_tick = 1'b0;
      put(8'h5A);
      repeat (30) @(negedge clk);
      chk(txd == 1'b1, "R12", "no start without tick", int'(txd), 1);
      chk(busy == 1'b1, "R12", "pending busy", int'(busy), 1);
      baud_tick = 1'b1;
      wait_fall(w);
      chk(w == 1, "R12", "start on first tick", w, 1);
      decode(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, "R12");
      expect_idle("R12");

      // R8 disable during a frame; R6 busy with transmitter off
      put(8'hC3);
      put(8'h3C);
      wait_fall(w);
      tx_enable = 1'b0;
      decode(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, "R8");
      repeat (2) @(negedge clk);
      chk(txd == 1'b1, "R8", "no next start", int'(txd), 1);
      chk(busy == 1'b1, "R6", "busy while disabled", int'(busy), 1);
      chk(tx_empty == 1'b0, "R6", "empty flag", int'(tx_empty), 0);
      tx_enable = 1'b1;
      wait_fall(w);
      decode(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, "R8");
      expect_idle("R8");

      // R9 clear-to-send gating
      cts_flow_en = 1'b1;
      cts_ok = 1'b0;
      put(8'h81);
      repeat (30) @(negedge clk);
      chk(txd == 1'b1, "R9", "held by cts", int'(txd), 1);
      cts_ok = 1'b1;
      wait_fall(w);
      chk(w == 1, "R9", "start after cts", w, 1);
      cts_ok = 1'b0;
      decode(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, "R9");
      expect_idle("R9");
      put(8'h18);
      repeat (30) @(negedge clk);
      chk(txd == 1'b1, "R9", "held again", int'(txd), 1);
      cts_ok = 1'b1;
      wait_fall(w);
      decode(8'h18, 2'd3, 1'b0, 1'b0, 1'b0, "R9");
      expect_idle("R9");
      cts_flow_en = 1'b0;

      // R10 break after the current character
      put(8'h0F);
      wait_fall(w);
      send_break = 1'b1;
      decode(8'h0F, 2'd3, 1'b0, 1'b0, 1'b0, "R10");
      repeat (2) @(negedge clk);
      chk(txd == 1'b0, "R10", "break low", int'(txd), 0);
      put(8'h66);
      repeat (40) @(negedge clk);
      chk(txd == 1'b0, "R10", "break held, no start", int'(txd), 0);
      chk(busy == 1'b1, "R10", "pending busy", int'(busy), 1);
      send_break = 1'b0;
      wait_fall(w);
      decode(8'h66, 2'd3, 1'b0, 1'b0, 1'b0, "R10");
      expect_idle("R10");

      // R11 queue fill, drop when full, order, back-to-back (R5)
      tx_enable = 1'b0;
      for (int i = 0; i < 16; i++) put(8'h30 + 8'(i));
      chk(tx_full == 1'b1, "R11", "queue full", int'(tx_full), 1);
      put(8'hEE);
      tx_enable = 1'b1;
      wait_fall(w);
      for (int i = 0; i < 16; i++) begin
         decode(8'h30 + 8'(i), 2'd3, 1'b0, 1'b0, 1'b0, "R11");
         if (i < 15) begin
            wait_fall(w);
            chk(w == 1, "R5", "no gap between frames", w, 1);
         end
      end
      expect_idle("R11");

      // R11 character mode: one holding byte
      fifo_mode = 1'b0;
      tx_enable = 1'b0;
      put(8'hA1);
      chk(tx_full == 1'b1, "R11", "holding full", int'(tx_full), 1);
      put(8'hB2);
      tx_enable = 1'b1;
      wait_fall(w);
      decode(8'hA1, 2'd3, 1'b0, 1'b0, 1'b0, "R11");
      expect_idle("R11");

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule